// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the hardwired control unit of a small 16-bit accumulator processor. It holds a 4-bit state register and, from the current state, the 5-bit operation code of the instruction word and the sign bit of the accumulator, it decides the next state. In the same step it drives every control point of the datapath: the ALU function, the memory bus operation, the source for the program counter, the source for the address register, and the load enables of the data-in register and the accumulator. Eight instruction kinds are supported: complement, halve (shift right), add and AND with an immediate, load, store, unconditional jump and branch-if-negative. The indirect bit of the instruction word is not looked at.

The datapath keeps one rule at every fetch: the address register already points at the instruction being read, and the program counter already points at the one after it (byte addresses, so it is two ahead). Each execute path ends by copying the program counter into the address register and stepping the counter by two, or, for a taken branch or a jump, by loading both from the data-in register and stepping the counter past the target. The operation code is presented on `opcode_in` while the instruction is on the data bus during fetch; the sequencer keeps its own copy for the execute states that need it, so the datapath may change `opcode_in` freely afterwards.

Top module: `acc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state becomes 0 (first reset step) at that edge; `bus_op` is idle (00) whenever `rst_n` is low and in both reset steps.
- R2: State 0 selects program-counter source zero (01) and goes to state 1; state 1 selects address source PC (01) and PC source step-by-two (10) and goes to fetch (state 2).
- R3: In fetch, `bus_op` is read (01) and `di_we` is 1; the next state follows the operation code: 0000x to state 4, 00010 to state 11, 00011 to state 13, 00100 to state 5, 00101 to state 8, 0011x to state 3. The code seen in fetch is held for the execute states.
- R4: State 3 sets `ac_we`, selects ALU function AND (010) for held code 00110 and ADD (011) for 00111, selects address source PC and PC step, then returns to fetch.
- R5: State 4 sets `ac_we`, selects ALU complement (001) for held code 00000 and halve (100) for 00001, restores the fetch rule, then returns to fetch.
- R6: A load visits states 8, 9, 10: state 8 selects address source DI (10); state 9 reads with `di_we`; state 10 sets `ac_we` with ALU pass (000), restores the fetch rule, and returns to fetch.
- R7: A store visits states 5 and 6: state 5 selects address source DI with the bus idle; state 6 writes (10) while selecting address source PC and PC step, then returns to fetch.
- R8: State 11 selects address source PC and PC step; with `acc_sign` 0 the next state is fetch.
- R9: With `acc_sign` 1 in state 11 the next state is 12, which selects address source DI and PC source target (11, data-in plus two), then returns to fetch.
- R10: State 13 selects address source DI and PC source target and returns to fetch.
- R11: A fetched code whose two top bits are not 00 is skipped: fetch itself selects address source PC and PC step and the next state is fetch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_in | input | 5 | Operation code field of the word on the data bus |
| acc_sign | input | 1 | Bit 15 of the accumulator |
| state_o | output | 4 | Current state code |
| alu_fn | output | 3 | ALU function: 000 pass A, 001 complement B, 010 AND, 011 ADD, 100 halve B |
| bus_op | output | 2 | Memory operation: 00 idle, 01 read, 10 write |
| pc_next | output | 2 | PC source: 00 hold, 01 zero, 10 PC plus two, 11 data-in plus two |
| adr_src | output | 2 | Address register source: 00 hold, 01 PC, 10 data-in |
| di_we | output | 1 | Load enable of the data-in register |
| ac_we | output | 1 | Load enable of the accumulator |

## Verification
A wrong state code appears at the ports in the very next cycle, both on `state_o` and as a control word that does not fit the instruction: a missing bus read in fetch, a write outside the second store step, or an address register loaded from the wrong source. A wrong path length shows as the return to fetch arriving one cycle early or late, so each instruction kind is timed from dispatch back to fetch. A held operation code that was not captured shows only in the arithmetic and shift steps, which is why the driven code is scrambled right after every fetch.

// File: rtl/acc_seq_pkg.sv
// Shared encodings for the accumulator sequencer.
// Assumes a 5-bit operation code and a 16-state code space (4 bits).
package acc_seq_pkg;

    localparam int OPC_W   = 5;
    localparam int STATE_W = 4;
    localparam int GRP_W   = 2;               // top code bits that select the implemented group
    localparam int SEL_W   = OPC_W - GRP_W;   // bits that pick the instruction inside the group

    typedef enum logic [STATE_W-1:0] {
        ST_RST0    = 4'd0,
        ST_RST1    = 4'd1,
        ST_FETCH   = 4'd2,
        ST_ARITH   = 4'd3,
        ST_UNARY   = 4'd4,
        ST_ST_ADR  = 4'd5,
        ST_ST_WR   = 4'd6,
        ST_ST_RSV  = 4'd7,
        ST_LD_ADR  = 4'd8,
        ST_LD_RD   = 4'd9,
        ST_LD_WB   = 4'd10,
        ST_BR_CHK  = 4'd11,
        ST_BR_TAKE = 4'd12,
        ST_JMP     = 4'd13
    } seq_state_e;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_INV  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_ADD  = 3'd3,
        ALU_HALF = 3'd4
    } alu_fn_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    typedef enum logic [1:0] {
        PCN_HOLD   = 2'd0,
        PCN_ZERO   = 2'd1,
        PCN_STEP   = 2'd2,
        PCN_TARGET = 2'd3
    } pc_next_e;

    typedef enum logic [1:0] {
        ADR_HOLD = 2'd0,
        ADR_PC   = 2'd1,
        ADR_DI   = 2'd2
    } adr_src_e;

    typedef struct packed {
        alu_fn_e  alu;
        bus_op_e  bus;
        pc_next_e pcn;
        adr_src_e adr;
        logic     di_we;
        logic     ac_we;
    } ctrl_t;

    // Selector values inside the implemented group (low three code bits)
    localparam logic [SEL_W-1:0] SEL_INV  = 3'b000;
    localparam logic [SEL_W-1:0] SEL_HALF = 3'b001;
    localparam logic [SEL_W-1:0] SEL_BRN  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_JMP  = 3'b011;
    localparam logic [SEL_W-1:0] SEL_STO  = 3'b100;
    localparam logic [SEL_W-1:0] SEL_LDA  = 3'b101;
    localparam logic [SEL_W-1:0] SEL_AND  = 3'b110;
    localparam logic [SEL_W-1:0] SEL_ADD  = 3'b111;

    localparam ctrl_t CTRL_IDLE = '{alu: ALU_PASS, bus: BUS_IDLE, pcn: PCN_HOLD,
                                    adr: ADR_HOLD, di_we: 1'b0, ac_we: 1'b0};

endpackage

// File: rtl/acc_seq_state.sv
// State register and held operation code.
// Captures the code presented during fetch so execute steps do not depend
// on the live data bus. Synchronous active-low reset.
module acc_seq_state
    import acc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       nxt,
    input  logic [OPC_W-1:0] fetch_opc,
    output seq_state_e       cur,
    output logic [OPC_W-1:0] opc_q
);

    logic rst_seen;

    // Advance the state, or force the first reset step.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_RST0;
        else        cur <= nxt;
    end

    // Hold the code of the instruction being fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)               opc_q <= '0;
        else if (cur == ST_FETCH) opc_q <= fetch_opc;
    end

    // Remember that reset was sampled at the previous edge (checking only).
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // A sampled reset must leave the machine in the first reset step.
    always @(posedge clk) begin
        if (rst_seen) begin
            assert_reset_state_R1: assert (cur == ST_RST0)
                else $error("state %0d after reset", cur);
        end
    end

endmodule

// File: rtl/acc_seq_next.sv
// Next-state logic. Purely combinational.
// Assumes acc_sign is stable during the branch-check step.
module acc_seq_next
    import acc_seq_pkg::*;
(
    input  seq_state_e       cur,
    input  logic [OPC_W-1:0] fetch_opc,
    input  logic             acc_sign,
    output seq_state_e       nxt
);

    logic             grp_ok;
    logic [SEL_W-1:0] sel;

    // Split the live code into group and selector.
    always_comb begin
        grp_ok = (fetch_opc[OPC_W-1 -: GRP_W] == '0);
        sel    = fetch_opc[SEL_W-1:0];
    end

    // Pick the successor of the current state.
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_RST0:   nxt = ST_RST1;
            ST_RST1:   nxt = ST_FETCH;
            ST_FETCH: begin
                if (!grp_ok) begin
                    nxt = ST_FETCH;
                end else begin
                    case (sel)
                        SEL_INV, SEL_HALF: nxt = ST_UNARY;
                        SEL_BRN:           nxt = ST_BR_CHK;
                        SEL_JMP:           nxt = ST_JMP;
                        SEL_STO:           nxt = ST_ST_ADR;
                        SEL_LDA:           nxt = ST_LD_ADR;
                        default:           nxt = ST_ARITH;
                    endcase
                end
            end
            ST_ST_ADR: nxt = ST_ST_WR;
            ST_LD_ADR: nxt = ST_LD_RD;
            ST_LD_RD:  nxt = ST_LD_WB;
            ST_BR_CHK: nxt = acc_sign ? ST_BR_TAKE : ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/acc_seq_decode.sv
// Control-word decoder. Purely combinational.
// Every step that ends an instruction restores the fetch rule
// (address <- PC, PC <- PC + 2) unless it redirects to a target.
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  seq_state_e       cur,
    input  logic [OPC_W-1:0] fetch_opc,
    input  logic [OPC_W-1:0] opc_q,
    output ctrl_t            ctrl
);

    logic fetch_known;

    // Decide whether the live code belongs to the implemented group.
    always_comb begin
        fetch_known = (fetch_opc[OPC_W-1 -: GRP_W] == '0);
    end

    // Drive the control word for the current step.
    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (cur)
            ST_RST0: begin
                ctrl.pcn = PCN_ZERO;
            end
            ST_RST1: begin
                ctrl.adr = ADR_PC;
                ctrl.pcn = PCN_STEP;
            end
            ST_FETCH: begin
                ctrl.bus   = BUS_READ;
                ctrl.di_we = 1'b1;
                if (!fetch_known) begin
                    ctrl.adr = ADR_PC;
                    ctrl.pcn = PCN_STEP;
                end
            end
            ST_ARITH: begin
                ctrl.alu   = opc_q[0] ? ALU_ADD : ALU_AND;
                ctrl.ac_we = 1'b1;
                ctrl.adr   = ADR_PC;
                ctrl.pcn   = PCN_STEP;
            end
            ST_UNARY: begin
                ctrl.alu   = opc_q[0] ? ALU_HALF : ALU_INV;
                ctrl.ac_we = 1'b1;
                ctrl.adr   = ADR_PC;
                ctrl.pcn   = PCN_STEP;
            end
            ST_ST_ADR, ST_LD_ADR: begin
                ctrl.adr = ADR_DI;
            end
            ST_ST_WR: begin
                ctrl.bus = BUS_WRITE;
                ctrl.adr = ADR_PC;
                ctrl.pcn = PCN_STEP;
            end
            ST_LD_RD: begin
                ctrl.bus   = BUS_READ;
                ctrl.di_we = 1'b1;
            end
            ST_LD_WB: begin
                ctrl.alu   = ALU_PASS;
                ctrl.ac_we = 1'b1;
                ctrl.adr   = ADR_PC;
                ctrl.pcn   = PCN_STEP;
            end
            ST_BR_CHK: begin
                ctrl.adr = ADR_PC;
                ctrl.pcn = PCN_STEP;
            end
            ST_BR_TAKE, ST_JMP: begin
                ctrl.adr = ADR_DI;
                ctrl.pcn = PCN_TARGET;
            end
            default: begin
                ctrl = CTRL_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/acc_seq_ctrl.sv
// Top of the accumulator instruction sequencer.
// Joins state register, next-state logic and decoder; keeps the memory
// bus idle whenever reset is asserted. Assumes opcode_in carries the
// instruction code while the fetch read is on the bus.
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode_in,
    input  logic                 acc_sign,
    output logic [STATE_W-1:0]   state_o,
    output logic [2:0]           alu_fn,
    output logic [1:0]           bus_op,
    output logic [1:0]           pc_next,
    output logic [1:0]           adr_src,
    output logic                 di_we,
    output logic                 ac_we
);

    seq_state_e       cur;
    seq_state_e       nxt;
    logic [OPC_W-1:0] opc_q;
    ctrl_t            ctrl;

    acc_seq_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (nxt),
        .fetch_opc (opcode_in),
        .cur       (cur),
        .opc_q     (opc_q)
    );

    acc_seq_next u_next (
        .cur       (cur),
        .fetch_opc (opcode_in),
        .acc_sign  (acc_sign),
        .nxt       (nxt)
    );

    acc_seq_decode u_dec (
        .cur       (cur),
        .fetch_opc (opcode_in),
        .opc_q     (opc_q),
        .ctrl      (ctrl)
    );

    // Present the control word; reset silences the memory bus.
    always_comb begin
        state_o = cur;
        alu_fn  = ctrl.alu;
        bus_op  = rst_n ? ctrl.bus : BUS_IDLE;
        pc_next = ctrl.pcn;
        adr_src = ctrl.adr;
        di_we   = ctrl.di_we;
        ac_we   = ctrl.ac_we;
    end

    // Reset steps never touch memory.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_RST0 || cur == ST_RST1) |-> bus_op == BUS_IDLE);

    // Reset sequence order.
    assert_reset_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_RST0 |=> cur == ST_RST1);
    assert_reset_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_RST1 |=> cur == ST_FETCH);

    // Fetch always reads into DI and dispatches to a legal first step.
    assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_FETCH |-> (bus_op == BUS_READ && di_we));
    assert_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_FETCH |=> cur inside {ST_FETCH, ST_ARITH, ST_UNARY, ST_ST_ADR,
                                        ST_LD_ADR, ST_BR_CHK, ST_JMP});

    // Two-operand step writes AC with AND or ADD.
    assert_arith_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_ARITH |-> (ac_we && (alu_fn == ALU_AND || alu_fn == ALU_ADD)));

    // One-operand step writes AC with complement or halve.
    assert_unary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_UNARY |-> (ac_we && (alu_fn == ALU_INV || alu_fn == ALU_HALF)));

    // Load operand read.
    assert_load_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_LD_RD |-> (bus_op == BUS_READ && di_we) ##1 cur == ST_LD_WB);

    // Store write restores the fetch rule in the same step.
    assert_store_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_ST_WR |-> (bus_op == BUS_WRITE && adr_src == ADR_PC && pc_next == PCN_STEP));

    // Branch on sign.
    assert_branch_not_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_BR_CHK && !acc_sign) |=> cur == ST_FETCH);
    assert_branch_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_BR_CHK && acc_sign) |=> cur == ST_BR_TAKE);

    // Jump redirects both address and PC.
    assert_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_JMP |-> (adr_src == ADR_DI && pc_next == PCN_TARGET) ##1 cur == ST_FETCH);

    // Outside reset, the bus is never driven to the unused code.
    assert_bus_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_op != 2'b11);

endmodule

// File: tb/sim_acc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_acc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] opcode_in;
    logic       acc_sign;
    logic [3:0] state_o;
    logic [2:0] alu_fn;
    logic [1:0] bus_op;
    logic [1:0] pc_next;
    logic [1:0] adr_src;
    logic       di_we;
    logic       ac_we;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    acc_seq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode_in (opcode_in),
        .acc_sign  (acc_sign),
        .state_o   (state_o),
        .alu_fn    (alu_fn),
        .bus_op    (bus_op),
        .pc_next   (pc_next),
        .adr_src   (adr_src),
        .di_we     (di_we),
        .ac_we     (ac_we)
    );

    // Encodings taken from the requirements
    localparam logic [3:0] S_R0 = 4'd0, S_R1 = 4'd1, S_FE = 4'd2, S_LDA = 4'd8,
                           S_LRD = 4'd9, S_LWB = 4'd10, S_SAD = 4'd5, S_SWR = 4'd6,
                           S_BCK = 4'd11, S_BTK = 4'd12, S_JMP = 4'd13;
    localparam logic [1:0] B_IDLE = 2'd0, B_RD = 2'd1, B_WR = 2'd2;
    localparam logic [1:0] P_ZERO = 2'd1, P_STEP = 2'd2, P_TGT = 2'd3;
    localparam logic [1:0] A_PC = 2'd1, A_DI = 2'd2;

    // Vector: opcode, sign, first state, cycles until fetch, AC written, ALU code, requirement
    localparam int NV = 11;
    localparam logic [20:0] VEC [NV] = '{
        {5'b00000, 1'b0, 4'd4,  3'd1, 1'b1, 3'd1, 4'd5},
        {5'b00001, 1'b1, 4'd4,  3'd1, 1'b1, 3'd4, 4'd5},
        {5'b00110, 1'b0, 4'd3,  3'd1, 1'b1, 3'd2, 4'd4},
        {5'b00111, 1'b1, 4'd3,  3'd1, 1'b1, 3'd3, 4'd4},
        {5'b00101, 1'b0, 4'd8,  3'd3, 1'b1, 3'd0, 4'd6},
        {5'b00100, 1'b1, 4'd5,  3'd2, 1'b0, 3'd0, 4'd7},
        {5'b00010, 1'b0, 4'd11, 3'd1, 1'b0, 3'd0, 4'd8},
        {5'b00010, 1'b1, 4'd11, 3'd2, 1'b0, 3'd0, 4'd9},
        {5'b00011, 1'b0, 4'd13, 3'd1, 1'b0, 3'd0, 4'd10},
        {5'b01000, 1'b0, 4'd2,  3'd0, 1'b0, 3'd0, 4'd11},
        {5'b11111, 1'b1, 4'd2,  3'd0, 1'b0, 3'd0, 4'd11}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        opcode_in = 5'b00000;
        acc_sign  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset holds the first step, bus idle; R2: PC cleared there
        chk(state_o == S_R0, "R1", state_o, S_R0);
        chk(bus_op == B_IDLE, "R1", bus_op, B_IDLE);
        chk(pc_next == P_ZERO, "R2", pc_next, P_ZERO);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(state_o == S_R1, "R2", state_o, S_R1);
        chk(adr_src == A_PC && pc_next == P_STEP, "R2", {adr_src, pc_next}, {A_PC, P_STEP});
        chk(bus_op == B_IDLE, "R1", bus_op, B_IDLE);
        @(negedge clk); #1;
        chk(state_o == S_FE, "R2", state_o, S_FE);

        // Table walk: dispatch, path length and AC write per instruction kind
        for (int v = 0; v < NV; v++) begin
            logic [4:0] opc;
            logic       sgn;
            logic [3:0] first;
            logic [2:0] len;
            logic       expac;
            logic [2:0] expalu;
            int         req;
            int         n;
            bit         acseen;
            logic [2:0] aluseen;
            string      tag;
            {opc, sgn, first, len, expac, expalu} = VEC[v][20:4];
            req = int'(VEC[v][3:0]);
            tag = $sformatf("R%0d", req);
            opcode_in = opc;
            acc_sign  = sgn;
            #1;
            // R3: every fetch reads into DI
            chk(bus_op == B_RD && di_we, "R3", {bus_op, di_we}, {B_RD, 1'b1});
            if (first == S_FE) begin
                // R11: a skipped code restores the fetch rule inside fetch
                chk(adr_src == A_PC && pc_next == P_STEP, "R11",
                    {adr_src, pc_next}, {A_PC, P_STEP});
            end
            @(negedge clk);
            opcode_in = 5'b11110;   // scramble: execute steps must use the held code (R3)
            #1;
            chk(state_o == first, tag, state_o, first);
            n = 0;
            acseen = 1'b0;
            aluseen = 3'd0;
            while (state_o != S_FE && n < 8) begin
                if (ac_we) begin
                    acseen  = 1'b1;
                    aluseen = alu_fn;
                end
                n++;
                @(negedge clk); #1;
            end
            chk(n == int'(len), tag, n, len);
            chk(acseen == expac, tag, acseen, expac);
            if (expac) chk(aluseen == expalu, tag, aluseen, expalu);
        end

        // Directed: load steps (R6)
        opcode_in = 5'b00101; acc_sign = 1'b0; #1;
        @(negedge clk); #1;
        chk(state_o == S_LDA && adr_src == A_DI && bus_op == B_IDLE, "R6", state_o, S_LDA);
        @(negedge clk); #1;
        chk(state_o == S_LRD && bus_op == B_RD && di_we, "R6", bus_op, B_RD);
        @(negedge clk); #1;
        chk(state_o == S_LWB && ac_we && alu_fn == 3'd0, "R6", alu_fn, 0);
        chk(adr_src == A_PC && pc_next == P_STEP, "R6", {adr_src, pc_next}, {A_PC, P_STEP});
        @(negedge clk); #1;

        // Directed: store steps (R7)
        opcode_in = 5'b00100; #1;
        @(negedge clk); #1;
        chk(state_o == S_SAD && adr_src == A_DI && bus_op == B_IDLE, "R7", bus_op, B_IDLE);
        @(negedge clk); #1;
        chk(state_o == S_SWR && bus_op == B_WR, "R7", bus_op, B_WR);
        chk(adr_src == A_PC && pc_next == P_STEP && !ac_we, "R7",
            {adr_src, pc_next}, {A_PC, P_STEP});
        @(negedge clk); #1;

        // Directed: branch not taken, then taken (R8, R9)
        opcode_in = 5'b00010; acc_sign = 1'b0; #1;
        @(negedge clk); #1;
        chk(state_o == S_BCK && adr_src == A_PC && pc_next == P_STEP, "R8",
            {adr_src, pc_next}, {A_PC, P_STEP});
        @(negedge clk); #1;
        chk(state_o == S_FE, "R8", state_o, S_FE);
        acc_sign = 1'b1; #1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk(state_o == S_BTK && adr_src == A_DI && pc_next == P_TGT, "R9",
            {adr_src, pc_next}, {A_DI, P_TGT});
        chk(bus_op == B_IDLE, "R9", bus_op, B_IDLE);
        @(negedge clk); #1;
        acc_sign = 1'b0;

        // Directed: jump (R10)
        opcode_in = 5'b00011; #1;
        @(negedge clk); #1;
        chk(state_o == S_JMP && adr_src == A_DI && pc_next == P_TGT, "R10",
            {adr_src, pc_next}, {A_DI, P_TGT});
        @(negedge clk); #1;
        chk(state_o == S_FE, "R10", state_o, S_FE);

        // Directed: reset during a load read silences the bus at once (R1)
        opcode_in = 5'b00101; #1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk(state_o == S_LRD, "R1", state_o, S_LRD);
        rst_n = 1'b0; #1;
        chk(bus_op == B_IDLE, "R1", bus_op, B_IDLE);
        @(negedge clk); #1;
        chk(state_o == S_R0, "R1", state_o, S_R0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk(state_o == S_FE, "R2", state_o, S_FE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule